// File: doc/BRIEF.md
# AB-Synchronized Transfer Parameter Engine

The engine owns one active transfer parameter set and a small store of link slots. Each trigger consumes one frame of the active set in AB-synchronized fashion: it emits a single transfer request describing a frame of BCNT arrays of ACNT bytes, together with the source and destination addresses and the signed in-frame array strides. After a non-final frame, the engine moves the source and destination addresses on by their signed frame strides and counts the remaining frames down. After the final frame, it either keeps the set (static), copies a link slot into the active set, or turns the set into a null set. The data movement itself is done by a separate transfer unit that consumes the request.

Completion is signalled in two ways, both taken from the options word. One is a sticky interrupt-pending bit indexed by the completion code, cleared by writing one to it. The other is a one-cycle chain pulse that carries the same code. Intermediate frames and final frames have separate enables for each form. A trigger on a null set issues no request but still counts as a final completion.

Top module: `ab_param_engine`

## Requirements
- R1: After reset, reqValid, chainValid and intPend are all zero. The active set is null (CCNT zero), so a trigger issues no request.
- R2: A trigger on an active set with CCNT not zero sets reqValid for exactly the following cycle. In that cycle reqSrc, reqDst, reqAcnt, reqBcnt, reqSrcBidx and reqDstBidx equal the set's fields as they stood when triggered.
- R3: A trigger with CCNT greater than 1 is intermediate. Afterwards, SRC is increased by the sign-extended source frame stride and DST by the sign-extended destination frame stride, both modulo 2^32, and CCNT is decreased by one.
- R4: A trigger with CCNT equal to 1 is final. If the static bit (options bit 0) is clear and the link field holds a value from 1 to NUM_SLOTS-1, the active set is replaced by that slot's contents.
- R5: After a non-static final trigger whose link field is 0xFFFF, 0, or NUM_SLOTS or above, the active set becomes null: ACNT, BCNT and CCNT become zero and the link becomes 0xFFFF. Every other field is kept. A trigger on a null set issues no request, counts as final and leaves the set unchanged.
- R6: With the static bit set, a final trigger leaves the active set untouched, so the next trigger issues the same frame again.
- R7: Options bit 1 enables the interrupt for intermediate completions and bit 2 enables it for final completions. When enabled, the trigger sets intPend[code] in the next cycle. The code is taken from options bits starting at bit 8, with a width of log2(NUM_CODES) (bits 12:8 by default).
- R8: Options bit 3 enables chaining for intermediate completions and bit 4 enables it for final completions. When enabled, chainValid is high for the next cycle and chainCode equals the code.
- R9: Writing one to intClr clears the matching intPend bit in the next cycle. If a completion sets that same bit in the same cycle, the set wins.
- R10: wrEn with wrSlot 0 loads wrData into the active set, and any other wrSlot stores wrData into that link slot without disturbing the active set. The packed layout, from the top bit down, is: options [255:224], SRC [223:192], DST [191:160], ACNT [159:144], BCNT [143:128], source B-stride [127:112], destination B-stride [111:96], source C-stride [95:80], destination C-stride [79:64], CCNT [63:48], BCNT reload [47:32], link [31:16], unused [15:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Parameter write strobe |
| wrSlot | input | log2(NUM_SLOTS) | Slot written; 0 is the active set |
| wrData | input | 256 | Packed parameter set |
| trig | input | 1 | Trigger event, one frame per cycle high |
| intClr | input | NUM_CODES | Write-one-to-clear for intPend |
| reqValid | output | 1 | Transfer request valid |
| reqSrc | output | 32 | Request source address |
| reqDst | output | 32 | Request destination address |
| reqAcnt | output | 16 | Bytes per array |
| reqBcnt | output | 16 | Arrays per frame |
| reqSrcBidx | output | 16 | Signed source array stride |
| reqDstBidx | output | 16 | Signed destination array stride |
| chainValid | output | 1 | Chain pulse |
| chainCode | output | log2(NUM_CODES) | Code carried by the chain pulse |
| intPend | output | NUM_CODES | Sticky interrupt-pending bits |

## Verification
The assertions assume that trig is low while reset is held. They also assume that no write to slot 0 coincides with a trigger, since in that case the write overrides the update. The stimulus drives every input at the falling edge and holds trig low during reset. It loads link slots before any set that points at them, and never writes slot 0 in a triggering cycle. Frame strides include negative values, so the sign extension is exercised against the bench's own arithmetic.

// File: rtl/pe_pkg.sv
package pe_pkg;
  localparam int SET_W = 256;
  localparam logic [15:0] NULL_LINK = 16'hFFFF;

  // options word bit positions
  localparam int OPT_STATIC    = 0;
  localparam int OPT_MID_INT   = 1;
  localparam int OPT_END_INT   = 2;
  localparam int OPT_MID_CHAIN = 3;
  localparam int OPT_END_CHAIN = 4;
  localparam int OPT_CODE_LSB  = 8;

  typedef struct packed {
    logic [31:0]        opt;
    logic [31:0]        src;
    logic [31:0]        dst;
    logic [15:0]        acnt;
    logic [15:0]        bcnt;
    logic signed [15:0] srcBidx;
    logic signed [15:0] dstBidx;
    logic signed [15:0] srcCidx;
    logic signed [15:0] dstCidx;
    logic [15:0]        ccnt;
    logic [15:0]        bcntRld;
    logic [15:0]        link;
    logic [15:0]        spare;
  } paramSet_t;

  typedef struct packed {
    logic issue;
    logic advance;
    logic loadLink;
    logic makeNull;
    logic complete;
    logic chain;
  } peStrobe_t;
endpackage

// File: rtl/pe_ctrl.sv
module pe_ctrl (
  input  logic             trig,
  input  logic             isNull,
  input  logic             isLast,
  input  logic             isStatic,
  input  logic             linkOk,
  input  logic             midInt,
  input  logic             endInt,
  input  logic             midChain,
  input  logic             endChain,
  output pe_pkg::peStrobe_t st
);
  logic isFinal;
  logic endOfSet;

  assign isFinal  = isNull | isLast;
  assign endOfSet = trig & isLast & !isNull & !isStatic;

  always_comb begin
    st          = '0;
    st.issue    = trig & !isNull;
    st.advance  = trig & !isNull & !isLast;
    st.loadLink = endOfSet & linkOk;
    st.makeNull = endOfSet & !linkOk;
    st.complete = trig & (isFinal ? endInt : midInt);
    st.chain    = trig & (isFinal ? endChain : midChain);
  end
endmodule

// File: rtl/pe_datapath.sv
module pe_datapath #(
  parameter int NUM_SLOTS = 8,
  parameter int NUM_CODES = 32,
  localparam int SLOT_W = $clog2(NUM_SLOTS),
  localparam int CODE_W = $clog2(NUM_CODES)
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    wrEn,
  input  logic [SLOT_W-1:0]       wrSlot,
  input  pe_pkg::paramSet_t       wrSet,
  input  logic [NUM_CODES-1:0]    intClr,
  input  pe_pkg::peStrobe_t       st,
  output logic                    isNull,
  output logic                    isLast,
  output logic                    isStatic,
  output logic                    linkOk,
  output logic                    midInt,
  output logic                    endInt,
  output logic                    midChain,
  output logic                    endChain,
  output logic                    reqValid,
  output logic [31:0]             reqSrc,
  output logic [31:0]             reqDst,
  output logic [15:0]             reqAcnt,
  output logic [15:0]             reqBcnt,
  output logic [15:0]             reqSrcBidx,
  output logic [15:0]             reqDstBidx,
  output logic                    chainValid,
  output logic [CODE_W-1:0]       chainCode,
  output logic [NUM_CODES-1:0]    intPend
);
  import pe_pkg::*;

  paramSet_t act, actNext;
  paramSet_t slotMem [NUM_SLOTS];
  logic [CODE_W-1:0]    code;
  logic [NUM_CODES-1:0] pendNext;
  paramSet_t nullSet;

  assign code     = act.opt[OPT_CODE_LSB +: CODE_W];
  assign isNull   = (act.ccnt == 16'd0);
  assign isLast   = (act.ccnt == 16'd1);
  assign isStatic = act.opt[OPT_STATIC];
  assign midInt   = act.opt[OPT_MID_INT];
  assign endInt   = act.opt[OPT_END_INT];
  assign midChain = act.opt[OPT_MID_CHAIN];
  assign endChain = act.opt[OPT_END_CHAIN];
  assign linkOk   = (act.link != NULL_LINK) && (act.link != 16'd0) &&
                    (act.link < 16'(NUM_SLOTS));

  always_comb begin
    nullSet      = act;
    nullSet.acnt = '0;
    nullSet.bcnt = '0;
    nullSet.ccnt = '0;
    nullSet.link = NULL_LINK;
  end

  always_comb begin
    actNext = act;
    if (st.advance) begin
      actNext.src  = act.src + {{16{act.srcCidx[15]}}, act.srcCidx};
      actNext.dst  = act.dst + {{16{act.dstCidx[15]}}, act.dstCidx};
      actNext.ccnt = act.ccnt - 16'd1;
    end
    if (st.loadLink) actNext = slotMem[act.link[SLOT_W-1:0]];
    if (st.makeNull) actNext = nullSet;
    if (wrEn && wrSlot == '0) actNext = wrSet;
  end

  always_comb begin
    pendNext = intPend & ~intClr;
    if (st.complete) pendNext[code] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_SLOTS; i++) slotMem[i] <= '0;
    end else if (wrEn && wrSlot != '0) begin
      slotMem[wrSlot] <= wrSet;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      act        <= '0;
      act.link   <= NULL_LINK;
      reqValid   <= 1'b0;
      reqSrc     <= '0;
      reqDst     <= '0;
      reqAcnt    <= '0;
      reqBcnt    <= '0;
      reqSrcBidx <= '0;
      reqDstBidx <= '0;
      chainValid <= 1'b0;
      chainCode  <= '0;
      intPend    <= '0;
    end else begin
      act        <= actNext;
      reqValid   <= st.issue;
      chainValid <= st.chain;
      intPend    <= pendNext;
      if (st.issue) begin
        reqSrc     <= act.src;
        reqDst     <= act.dst;
        reqAcnt    <= act.acnt;
        reqBcnt    <= act.bcnt;
        reqSrcBidx <= act.srcBidx;
        reqDstBidx <= act.dstBidx;
      end
      if (st.chain) chainCode <= code;
    end
  end
endmodule

// File: rtl/ab_param_engine.sv
module ab_param_engine #(
  parameter int NUM_SLOTS = 8,
  parameter int NUM_CODES = 32,
  localparam int SLOT_W = $clog2(NUM_SLOTS),
  localparam int CODE_W = $clog2(NUM_CODES)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 wrEn,
  input  logic [SLOT_W-1:0]    wrSlot,
  input  logic [255:0]         wrData,
  input  logic                 trig,
  input  logic [NUM_CODES-1:0] intClr,
  output logic                 reqValid,
  output logic [31:0]          reqSrc,
  output logic [31:0]          reqDst,
  output logic [15:0]          reqAcnt,
  output logic [15:0]          reqBcnt,
  output logic [15:0]          reqSrcBidx,
  output logic [15:0]          reqDstBidx,
  output logic                 chainValid,
  output logic [CODE_W-1:0]    chainCode,
  output logic [NUM_CODES-1:0] intPend
);
  pe_pkg::peStrobe_t st;
  pe_pkg::paramSet_t wrSet;
  logic isNull, isLast, isStatic, linkOk;
  logic midInt, endInt, midChain, endChain;

  assign wrSet = pe_pkg::paramSet_t'(wrData);

  pe_ctrl u_ctrl (
    .trig(trig), .isNull(isNull), .isLast(isLast), .isStatic(isStatic),
    .linkOk(linkOk), .midInt(midInt), .endInt(endInt),
    .midChain(midChain), .endChain(endChain), .st(st)
  );

  pe_datapath #(.NUM_SLOTS(NUM_SLOTS), .NUM_CODES(NUM_CODES)) u_dp (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSlot(wrSlot), .wrSet(wrSet),
    .intClr(intClr), .st(st),
    .isNull(isNull), .isLast(isLast), .isStatic(isStatic), .linkOk(linkOk),
    .midInt(midInt), .endInt(endInt), .midChain(midChain), .endChain(endChain),
    .reqValid(reqValid), .reqSrc(reqSrc), .reqDst(reqDst),
    .reqAcnt(reqAcnt), .reqBcnt(reqBcnt),
    .reqSrcBidx(reqSrcBidx), .reqDstBidx(reqDstBidx),
    .chainValid(chainValid), .chainCode(chainCode), .intPend(intPend)
  );
endmodule

// File: rtl/pe_checker.sv
module pe_checker #(
  parameter int NUM_CODES = 32
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 trig,
  input logic [NUM_CODES-1:0] intClr,
  input logic                 reqValid,
  input logic                 chainValid,
  input logic [NUM_CODES-1:0] intPend
);
  // R2: a request only ever follows a trigger
  a_r2_req_after_trig: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |-> $past(trig));

  // R8: a chain pulse only ever follows a trigger
  a_r8_chain_after_trig: assert property (@(posedge clk) disable iff (!rstN)
    chainValid |-> $past(trig));

  // R7: pending bits rise only after a trigger
  a_r7_pend_rise_on_trig: assert property (@(posedge clk) disable iff (!rstN)
    (|(intPend & ~$past(intPend))) |-> $past(trig));

  // R7: one completion sets at most one bit
  a_r7_one_new_bit: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(intPend & ~$past(intPend)));

  // R9: without a trigger, every bit written with one reads as zero
  a_r9_clear_takes: assert property (@(posedge clk) disable iff (!rstN)
    !$past(trig) |-> ((intPend & $past(intClr)) == '0));
endmodule

bind ab_param_engine pe_checker #(.NUM_CODES(NUM_CODES)) u_chk (
  .clk(clk), .rstN(rstN), .trig(trig), .intClr(intClr),
  .reqValid(reqValid), .chainValid(chainValid), .intPend(intPend)
);

// File: tb/tb_ab_param_engine.sv
`timescale 1ns/1ps
module tb_ab_param_engine;
  localparam int NS = 8;
  localparam int NC = 32;

  logic clk = 1'b0;
  logic rstN;
  logic wrEn;
  logic [2:0] wrSlot;
  logic [255:0] wrData;
  logic trig;
  logic [NC-1:0] intClr;
  logic reqValid, chainValid;
  logic [31:0] reqSrc, reqDst;
  logic [15:0] reqAcnt, reqBcnt, reqSrcBidx, reqDstBidx;
  logic [4:0] chainCode;
  logic [NC-1:0] intPend;

  ab_param_engine #(.NUM_SLOTS(NS), .NUM_CODES(NC)) dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSlot(wrSlot), .wrData(wrData),
    .trig(trig), .intClr(intClr), .reqValid(reqValid), .reqSrc(reqSrc),
    .reqDst(reqDst), .reqAcnt(reqAcnt), .reqBcnt(reqBcnt),
    .reqSrcBidx(reqSrcBidx), .reqDstBidx(reqDstBidx),
    .chainValid(chainValid), .chainCode(chainCode), .intPend(intPend)
  );

  always #10 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // reference model state
  logic [255:0] mAct;
  logic [255:0] mSlot [NS];
  logic         eReq, eChain;
  logic [31:0]  eSrc, eDst;
  logic [15:0]  eAcnt, eBcnt, eSb, eDb;
  logic [4:0]   eCode;
  logic [NC-1:0] ePend;

  function automatic logic [255:0] mk(input logic [31:0] opt, input logic [31:0] src,
      input logic [31:0] dst, input int acnt, input int bcnt, input int sb, input int db,
      input int sc, input int dc, input int ccnt, input int link);
    logic [255:0] v;
    v = '0;
    v[255:224] = opt;  v[223:192] = src; v[191:160] = dst;
    v[159:144] = 16'(acnt); v[143:128] = 16'(bcnt);
    v[127:112] = 16'(sb);   v[111:96]  = 16'(db);
    v[95:80]   = 16'(sc);   v[79:64]   = 16'(dc);
    v[63:48]   = 16'(ccnt); v[47:32]   = 16'(bcnt);
    v[31:16]   = 16'(link);
    return v;
  endfunction

  function automatic logic [31:0] opts(input bit stat, input bit mi, input bit ei,
      input bit mc, input bit ec, input int code);
    logic [31:0] o;
    o = '0;
    o[0] = stat; o[1] = mi; o[2] = ei; o[3] = mc; o[4] = ec;
    o[12:8] = 5'(code);
    return o;
  endfunction

  task automatic check(input string tag, input string what, input logic [63:0] act,
      input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic compare(input string tag);
    check(tag, "reqValid", 64'(reqValid), 64'(eReq));
    if (eReq) begin
      check(tag, "reqSrc", 64'(reqSrc), 64'(eSrc));
      check(tag, "reqDst", 64'(reqDst), 64'(eDst));
      check(tag, "reqAcnt/Bcnt", {32'(reqAcnt), 32'(reqBcnt)}, {32'(eAcnt), 32'(eBcnt)});
      check(tag, "reqBidx", {32'(reqSrcBidx), 32'(reqDstBidx)}, {32'(eSb), 32'(eDb)});
    end
    check(tag, "chainValid", 64'(chainValid), 64'(eChain));
    if (eChain) check(tag, "chainCode", 64'(chainCode), 64'(eCode));
    check(tag, "intPend", 64'(intPend), 64'(ePend));
  endtask

  // behavioural model of one clock edge
  task automatic model(input bit t, input bit w, input int ws, input logic [255:0] wd,
      input logic [NC-1:0] clr);
    logic [31:0] opt;
    int ccnt, link, code;
    bit isNull, fin;
    eReq = 0; eChain = 0;
    ePend = ePend & ~clr;
    if (t) begin
      opt = mAct[255:224];
      code = int'(opt[12:8]);
      ccnt = int'(mAct[63:48]);
      isNull = (ccnt == 0);
      fin = isNull || ccnt == 1;
      if (!isNull) begin
        eReq = 1; eSrc = mAct[223:192]; eDst = mAct[191:160];
        eAcnt = mAct[159:144]; eBcnt = mAct[143:128];
        eSb = mAct[127:112]; eDb = mAct[111:96];
      end
      if (fin ? opt[2] : opt[1]) ePend[code] = 1'b1;
      if (fin ? opt[4] : opt[3]) begin eChain = 1; eCode = 5'(code); end
      if (!isNull) begin
        if (!fin) begin
          mAct[223:192] = mAct[223:192] + 32'($signed(mAct[95:80]));
          mAct[191:160] = mAct[191:160] + 32'($signed(mAct[79:64]));
          mAct[63:48]   = 16'(ccnt - 1);
        end else if (!opt[0]) begin
          link = int'(mAct[31:16]);
          if (link >= 1 && link < NS) mAct = mSlot[link];
          else begin
            mAct[159:128] = '0; mAct[63:48] = '0; mAct[31:16] = 16'hFFFF;
          end
        end
      end
    end
    if (w) begin
      if (ws == 0) mAct = wd;
      else mSlot[ws] = wd;
    end
  endtask

  task automatic cyc(input string tag, input bit t, input bit w, input int ws,
      input logic [255:0] wd, input logic [NC-1:0] clr);
    trig = t; wrEn = w; wrSlot = 3'(ws); wrData = wd; intClr = clr;
    model(t, w, ws, wd, clr);
    @(posedge clk);
    @(negedge clk);
    compare(tag);
  endtask

  task automatic fire(input string tag);
    cyc(tag, 1, 0, 0, '0, '0);
  endtask

  task automatic idle(input string tag);
    cyc(tag, 0, 0, 0, '0, '0);
  endtask

  task automatic put(input string tag, input int ws, input logic [255:0] wd);
    cyc(tag, 0, 1, ws, wd, '0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    rstN = 0; trig = 0; wrEn = 0; wrSlot = '0; wrData = '0; intClr = '0;
    mAct = '0; mAct[31:16] = 16'hFFFF;
    for (int i = 0; i < NS; i++) mSlot[i] = '0;
    eReq = 0; eChain = 0; ePend = '0;
    eSrc = '0; eDst = '0; eAcnt = '0; eBcnt = '0; eSb = '0; eDb = '0; eCode = '0;
    repeat (3) @(negedge clk);
    rstN = 1;
    compare("R1");
    // R1: trigger on the null set after reset issues nothing
    fire("R1");
    idle("R1");

    // R10: link slots loaded first, active set written last
    put("R10", 3, mk(opts(0, 0, 0, 1, 1, 9), 32'h0000_5000, 32'h0000_6000,
        8, 2, 8, 8, 16, 16, 2, 16'hFFFF));
    put("R10", 0, mk(opts(0, 1, 1, 0, 0, 5), 32'h0000_1000, 32'h0000_2000,
        4, 3, 4, -4, 12, -12, 3, 3));
    idle("R10");
    // R2 R3 R7: intermediate frames move addresses, set intPend[5]
    fire("R3");
    idle("R3");
    fire("R3");
    // R9: clear bit 5 with no trigger
    cyc("R9", 0, 0, 0, '0, 32'h0000_0020);
    // R4 R7: final frame of first set, link to slot 3
    fire("R4");
    // R8: intermediate chain from slot 3
    fire("R8");
    // R5 R8: final of slot 3, null link, final chain pulse
    fire("R5");
    // R5: null set: no request, final chain still fires
    fire("R5");
    idle("R5");

    // R6 R9: static set, same-cycle set and clear of bit 7
    put("R6", 0, mk(opts(1, 1, 1, 0, 0, 7), 32'hFFFF_FFF0, 32'h0000_0010,
        16, 1, 16, 16, -32, 32, 1, 4));
    fire("R6");
    cyc("R9", 1, 0, 0, '0, 32'h0000_0080);
    cyc("R9", 0, 0, 0, '0, 32'hFFFF_FFFF);
    fire("R6");

    // R10: writing a link slot leaves the active set untouched
    put("R10", 2, mk(opts(0, 0, 1, 0, 0, 2), 32'h0000_AAAA, 32'h0000_BBBB,
        1, 1, 0, 0, 0, 0, 1, 0));
    fire("R10");

    // R5: out-of-range link becomes null, wrap-around on source address
    put("R5", 0, mk(opts(0, 0, 1, 0, 1, 31), 32'hFFFF_FFF8, 32'h0000_0100,
        2, 2, 2, 2, 8, 2, 2, 200));
    fire("R3");
    fire("R5");
    fire("R5");
    idle("R5");

    // R4: link to slot 2 (loaded earlier), then its null link 0
    put("R4", 0, mk(opts(0, 0, 0, 0, 0, 1), 32'h0000_0300, 32'h0000_0400,
        3, 3, 3, 3, 9, 9, 1, 2));
    fire("R4");
    fire("R4");
    fire("R5");
    idle("R5");

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule